// File: doc/BRIEF.md
# Fractional-Rate Wavetable Oscillator

The block produces a periodic audio waveform by reading a user-loaded table of 512 signed 16-bit samples. A 32-bit phase accumulator moves through the table in steps that can include a fraction of an entry, so the output pitch can be set to any frequency, not only to integer divisions of the clock. The frequency is f = inc * f_strobe / 2^32. Here f_strobe is the audio sample rate. For example, a 100 MHz core clock might give one strobe every 2000 clocks for a 50 kHz rate.

Software loads the table through a simple write port. It sets the step through an increment write port. It then pulses a strobe once per audio sample period. Each strobe produces one registered output sample, marked by a valid pulse. The table can be rewritten while the oscillator is playing. Linear interpolation between neighbouring entries is available and can be selected per strobe. When it is not selected, the oscillator outputs the nearest lower table entry.

Top module: `wavetable_osc`

## Requirements
- R1: After reset, `sample_o` is 0, `valid_o` is 0, the phase is 0 and the increment is 0.
- R2: A write with `tbl_we` high stores `tbl_wdata` at entry `tbl_waddr` (0..511). The next strobe that reads that entry returns the new value.
- R3: Each strobe reads the table at address phase[31:23], using the phase held before that strobe. It then adds the increment to the phase. The first strobe after reset reads entry 0.
- R4: The phase wraps modulo 2^32. The next address after 511 is 0, with no extra or missing step.
- R5: `valid_o` is high for exactly one cycle, two cycles after each strobe cycle. Back-to-back strobes give back-to-back valid cycles. `sample_o` changes only in cycles where `valid_o` is high.
- R6: With an increment of 0, every strobe returns the same table entry.
- R7: `phase_clr` sets the phase to 0 at the next edge and takes priority over the advance from a strobe in the same cycle. A strobe in that cycle still reads the phase held before the clear.
- R8: With `lerp_en` high in the strobe cycle, the output is s0 + floor((s1 - s0) * f / 256). Here s0 is the entry at phase[31:23], s1 is the entry at the next address (mod 512), and f is phase[22:15].
- R9: A write with `inc_we` high loads `inc_wdata`. A strobe in the same cycle still uses the old increment. Every later strobe uses the new one.
- R10: A table write and a strobe that reads the same entry in the same cycle return the entry's old contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tbl_we | input | 1 | Table write enable |
| tbl_waddr | input | 9 | Table entry to write |
| tbl_wdata | input | 16 | Signed sample to store |
| inc_we | input | 1 | Increment write enable |
| inc_wdata | input | 32 | New phase increment (9 integer, 23 fractional bits) |
| phase_clr | input | 1 | Synchronous phase clear |
| sample_stb | input | 1 | One pulse per audio sample period |
| lerp_en | input | 1 | Selects interpolated output for this strobe |
| sample_o | output | 16 | Signed output sample |
| valid_o | output | 1 | One-cycle pulse marking a new `sample_o` |

## Verification
A wrong phase or increment does not stay hidden. It shows up as a wrong `sample_o` at the very next valid pulse after the strobe that used it, and the error then builds up with every later strobe. A table whose entries all differ makes any address fault visible as a mismatch on the first affected sample. A fault in the strobe pipeline shows as a missing, extra or shifted valid pulse within two cycles. The reference model compares `valid_o` and `sample_o` on every clock, so a change at the wrong time is reported in the same cycle it happens.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned OSC_ADDR_W  = 9;
  localparam int unsigned OSC_DATA_W  = 16;
  localparam int unsigned OSC_PHASE_W = 32;
  localparam int unsigned OSC_LERP_W  = 8;
endpackage

// File: rtl/osc_phase_acc.sv
module osc_phase_acc
  import osc_pkg::*;
#(
  parameter int unsigned PHASE_W = OSC_PHASE_W,
  parameter int unsigned ADDR_W  = OSC_ADDR_W,
  parameter int unsigned LERP_W  = OSC_LERP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inc_we,
  input  logic [PHASE_W-1:0] inc_wdata,
  input  logic               step,
  input  logic               clr,
  output logic [ADDR_W-1:0]  addr_o,
  output logic [LERP_W-1:0]  frac_o
);
  localparam int unsigned FRAC_LO = PHASE_W - ADDR_W - LERP_W;

  logic [PHASE_W-1:0] phase_q, phase_d;
  logic [PHASE_W-1:0] inc_q, inc_d;

  always_comb begin
    inc_d = inc_we ? inc_wdata : inc_q;
    if (clr)       phase_d = '0;
    else if (step) phase_d = phase_q + inc_q;
    else           phase_d = phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      inc_q   <= '0;
    end else begin
      phase_q <= phase_d;
      inc_q   <= inc_d;
    end
  end

  assign addr_o = phase_q[PHASE_W-1 -: ADDR_W];
  assign frac_o = phase_q[FRAC_LO +: LERP_W];

  // R3 / R4: a strobe moves the phase by the increment held before it (mod 2^PHASE_W)
  p_step_adds_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> phase_q == $past(phase_q) + $past(inc_q));
  // R7: clear wins over the step
  p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> phase_q == '0);
  // R6: phase only moves on a strobe or clear
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(phase_q));
  // R9: increment changes only on a write
  p_inc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_we |=> $stable(inc_q));
endmodule

// File: rtl/osc_table_ram.sv
module osc_table_ram
  import osc_pkg::*;
#(
  parameter int unsigned ADDR_W = OSC_ADDR_W,
  parameter int unsigned DATA_W = OSC_DATA_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned NPORT = 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] port_addr [NPORT];
  logic [DATA_W-1:0] port_q    [NPORT];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // port p reads entry raddr+p; read-before-write on a same-cycle collision
  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign port_addr[p] = raddr + ADDR_W'(p);
    always_ff @(posedge clk) begin
      if (re) port_q[p] <= mem[port_addr[p]];
    end
  end

  assign rdata0 = port_q[0];
  assign rdata1 = port_q[1];
endmodule

// File: rtl/osc_lerp.sv
module osc_lerp
  import osc_pkg::*;
#(
  parameter int unsigned DATA_W = OSC_DATA_W,
  parameter int unsigned LERP_W = OSC_LERP_W
) (
  input  logic [DATA_W-1:0] s0,
  input  logic [DATA_W-1:0] s1,
  input  logic [LERP_W-1:0] frac,
  input  logic              en,
  output logic [DATA_W-1:0] y
);
  localparam int unsigned PW = DATA_W + LERP_W + 2;

  logic signed [PW-1:0] a_ext, b_ext, f_ext, prod, stepv, sum;

  always_comb begin
    a_ext = PW'($signed(s0));
    b_ext = PW'($signed(s1));
    f_ext = PW'($signed({1'b0, frac}));
    prod  = (b_ext - a_ext) * f_ext;
    stepv = prod >>> LERP_W;
    sum   = a_ext + stepv;
    y     = en ? sum[DATA_W-1:0] : s0;
  end
endmodule

// File: rtl/wavetable_osc.sv
module wavetable_osc
  import osc_pkg::*;
#(
  parameter int unsigned ADDR_W  = OSC_ADDR_W,
  parameter int unsigned DATA_W  = OSC_DATA_W,
  parameter int unsigned PHASE_W = OSC_PHASE_W,
  parameter int unsigned LERP_W  = OSC_LERP_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [ADDR_W-1:0]  tbl_waddr,
  input  logic [DATA_W-1:0]  tbl_wdata,
  input  logic               inc_we,
  input  logic [PHASE_W-1:0] inc_wdata,
  input  logic               phase_clr,
  input  logic               sample_stb,
  input  logic               lerp_en,
  output logic [DATA_W-1:0]  sample_o,
  output logic               valid_o
);
  // reset: asserted asynchronously, released on the second clock edge
  logic [1:0] rst_pipe;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic [ADDR_W-1:0] rd_addr;
  logic [LERP_W-1:0] rd_frac;
  logic [DATA_W-1:0] rd_s0, rd_s1, mix;

  osc_phase_acc #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .LERP_W(LERP_W)) u_phase (
    .clk(clk), .rst_n(rst_s_n), .inc_we(inc_we), .inc_wdata(inc_wdata),
    .step(sample_stb), .clr(phase_clr), .addr_o(rd_addr), .frac_o(rd_frac)
  );

  osc_table_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(tbl_we), .waddr(tbl_waddr), .wdata(tbl_wdata),
    .re(sample_stb), .raddr(rd_addr), .rdata0(rd_s0), .rdata1(rd_s1)
  );

  // stage 1: side information travelling alongside the RAM read
  logic              stb1_q, stb1_d, lerp1_q, lerp1_d;
  logic [LERP_W-1:0] frac1_q, frac1_d;
  // stage 2: output register
  logic [DATA_W-1:0] samp_q, samp_d;
  logic              vld_q, vld_d;

  osc_lerp #(.DATA_W(DATA_W), .LERP_W(LERP_W)) u_lerp (
    .s0(rd_s0), .s1(rd_s1), .frac(frac1_q), .en(lerp1_q), .y(mix)
  );

  always_comb begin
    stb1_d  = sample_stb;
    frac1_d = sample_stb ? rd_frac : frac1_q;
    lerp1_d = sample_stb ? lerp_en : lerp1_q;
    vld_d   = stb1_q;
    samp_d  = stb1_q ? mix : samp_q;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      stb1_q  <= 1'b0;
      frac1_q <= '0;
      lerp1_q <= 1'b0;
      vld_q   <= 1'b0;
      samp_q  <= '0;
    end else begin
      stb1_q  <= stb1_d;
      frac1_q <= frac1_d;
      lerp1_q <= lerp1_d;
      vld_q   <= vld_d;
      samp_q  <= samp_d;
    end
  end

  assign sample_o = samp_q;
  assign valid_o  = vld_q;

  // R5: strobe reaches the output after exactly two edges, one pulse each
  p_stb_to_stage1_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    sample_stb |=> stb1_q);
  p_stage1_to_valid_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    stb1_q |=> valid_o);
  p_no_spurious_valid_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !stb1_q |=> !valid_o);
  p_sample_hold_r5: assert property (@(posedge clk) disable iff (!rst_s_n)
    !valid_o |-> $stable(sample_o));
endmodule

// File: tb/tb_wavetable_osc.sv
module tb_wavetable_osc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [8:0]  tbl_waddr = '0;
  logic [15:0] tbl_wdata = '0;
  logic        inc_we = 1'b0;
  logic [31:0] inc_wdata = '0;
  logic        phase_clr = 1'b0;
  logic        sample_stb = 1'b0;
  logic        lerp_en = 1'b0;
  logic [15:0] sample_o;
  logic        valid_o;

  always #4 clk = ~clk;

  wavetable_osc dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .inc_we(inc_we), .inc_wdata(inc_wdata),
    .phase_clr(phase_clr), .sample_stb(sample_stb), .lerp_en(lerp_en),
    .sample_o(sample_o), .valid_o(valid_o)
  );

  int    checks = 0;
  int    failures = 0;
  int    cyc = 0;
  bit    live = 0;
  string cur_req = "R1";

  // behavioural reference
  int          tbl [512];
  logic [31:0] m_phase, m_inc;
  bit          m_v1, m_ip, e_valid;
  int          m_s0, m_s1, m_fr;
  logic [15:0] e_sample;

  function automatic logic [15:0] predict(int s0, int s1, int fr, bit ip);
    int d;
    if (!ip) return 16'(s0);
    d = (s1 - s0) * fr;
    return 16'(s0 + (d >>> 8));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = '0; m_inc = '0; m_v1 = 0; e_valid = 0; e_sample = '0;
    end else begin
      e_valid = m_v1;
      if (m_v1) e_sample = predict(m_s0, m_s1, m_fr, m_ip);
      m_v1 = sample_stb;
      if (sample_stb) begin
        m_s0 = tbl[int'(m_phase[31:23])];
        m_s1 = tbl[(int'(m_phase[31:23]) + 1) % 512];
        m_fr = int'(m_phase[22:15]);
        m_ip = lerp_en;
      end
      if (tbl_we) tbl[int'(tbl_waddr)] = int'($signed(tbl_wdata));
      if (phase_clr)       m_phase = '0;
      else if (sample_stb) m_phase = m_phase + m_inc;
      if (inc_we) m_inc = inc_wdata;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      checks++;
      if (valid_o !== e_valid) begin
        failures++;
        $display("FAIL %s/R5 valid_o actual=%0b expected=%0b t=%0t", cur_req, valid_o, e_valid, $time);
      end
      checks++;
      if (sample_o !== e_sample) begin
        failures++;
        $display("FAIL %s sample_o actual=%0d expected=%0d t=%0t", cur_req,
                 $signed(sample_o), $signed(e_sample), $time);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_tbl(int a, int d);
    tbl_we = 1; tbl_waddr = 9'(a); tbl_wdata = 16'(d);
    tick(); tbl_we = 0;
  endtask

  task automatic set_inc(logic [31:0] v);
    inc_we = 1; inc_wdata = v;
    tick(); inc_we = 0;
  endtask

  task automatic strobes(int n, int gap);
    for (int i = 0; i < n; i++) begin
      sample_stb = 1; tick(); sample_stb = 0;
      if (gap > 1) tick(gap - 1);
    end
  endtask

  initial begin
    tick(3);
    // R1: reset state at the ports
    checks++;
    if (sample_o !== 16'd0 || valid_o !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset sample=%0d valid=%0b expected 0/0", sample_o, valid_o);
    end
    rst_n = 1; tick(4);
    live = 1;

    // R2: load a table with all-distinct entries
    cur_req = "R2";
    for (int i = 0; i < 512; i++) wr_tbl(i, (i * 127 + 1000) % 65536 - 32768);
    // R1: zero increment after reset, first strobe reads entry 0
    cur_req = "R1";
    strobes(3, 4);
    // R3: one entry per strobe
    cur_req = "R3";
    set_inc(32'h0080_0000);
    strobes(20, 4);
    // R9: increment written in a strobe cycle
    cur_req = "R9";
    inc_we = 1; inc_wdata = 32'h01C0_0000; sample_stb = 1; tick();
    inc_we = 0; sample_stb = 0; tick(3);
    strobes(10, 3);
    // R4: wrap many times with an odd increment, then a near-full step
    cur_req = "R4";
    set_inc(32'h1234_5679);
    strobes(300, 2);
    set_inc(32'hFF7F_1234);
    strobes(40, 3);
    // R6: zero increment holds
    cur_req = "R6";
    set_inc(32'h0);
    strobes(10, 3);
    // R7: clear alone and together with a strobe
    cur_req = "R7";
    set_inc(32'h0345_6789);
    strobes(5, 3);
    phase_clr = 1; tick(); phase_clr = 0; tick(2);
    strobes(3, 3);
    phase_clr = 1; sample_stb = 1; tick(); phase_clr = 0; sample_stb = 0; tick(2);
    strobes(4, 3);
    // R5: back-to-back strobes
    cur_req = "R5";
    strobes(25, 1);
    tick(4);
    // R8: interpolation with fractional steps and table edits during play
    cur_req = "R8";
    lerp_en = 1;
    set_inc(32'h0123_4567);
    for (int k = 0; k < 150; k++) begin
      strobes(1, 2);
      if (k % 10 == 0) wr_tbl((k * 37) % 512, (k % 2 == 0) ? 32767 : -32768);
    end
    set_inc(32'hFFE0_1357);
    strobes(60, 1);
    lerp_en = 0;
    tick(4);
    // R10: write the entry being read in the strobe cycle; later reads see new data
    cur_req = "R10";
    set_inc(32'h0);
    strobes(2, 3);
    tbl_we = 1; tbl_waddr = m_phase[31:23]; tbl_wdata = 16'h5A5A; sample_stb = 1; tick();
    tbl_we = 0; sample_stb = 0; tick(3);
    // R2: following strobes return the rewritten entry
    cur_req = "R2";
    strobes(3, 3);
    tick(5);
    live = 0;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule